// File: doc/BRIEF.md
# Cascaded First-Word-Fall-Through FIFO Chain

This block builds one deep first-in first-out buffer out of several identical shallow stages placed in series. A producer writes into the head stage and a consumer reads from the tail stage. Each stage presents its oldest word on its output as soon as that word is visible, with no read needed to fetch it. Between neighbours, a word moves on by itself: whenever an upstream stage shows output-ready and the downstream stage shows input-ready, one shared clock edge pops the upstream stage and writes the downstream one. All stages run on a single clock, which serves as the write, read and transfer clock at once.

Each stage makes a newly written word visible three edges after the write, and makes a freed slot visible two edges after the read. The hop adds one edge on each internal boundary. So a word written into an empty chain of N stages shows up at the tail after 4(N-1)+3 edges. A read from a full chain shows up as input-ready at the head after 3(N-1)+2 edges. The head stage drives the almost-full flag and the tail stage drives the almost-empty flag. Stage count, stage depth, data width and both flag thresholds are parameters. The total capacity is the stage count times the stage depth.

Top module: `cfc_chain_fifo`

## Requirements
- R1: During and after reset, with no traffic, `in_ready` is 1, `out_ready` is 0, `almost_full` is 0 and `almost_empty` is 1.
- R2: Words leave through `rd_data` in exactly the order they were accepted at the write port, whether traffic is sequential or concurrent.
- R3: With no reads, the chain accepts exactly N_STAGES*STAGE_DEPTH words. Once transfers settle, `in_ready` is 0.
- R4: A write accepted at clock edge e into an empty chain makes `out_ready` rise right after edge e+4(N_STAGES-1)+3, and not earlier.
- R5: A read accepted at clock edge e from a full chain makes `in_ready` rise right after edge e+3(N_STAGES-1)+2, and not earlier.
- R6: A write attempted while `in_ready` is 0 is ignored: nothing is stored and later read data are unaffected.
- R7: A read attempted while `out_ready` is 0 is ignored: the chain state does not change and no word is lost.
- R8: `almost_full` is 1 exactly when the head stage's free slots number AF_LEVEL or fewer. Once settled, this happens with (N_STAGES-1)*STAGE_DEPTH + STAGE_DEPTH-AF_LEVEL words stored, and not with one word fewer.
- R9: `almost_empty` is 1 exactly when the tail stage holds AE_LEVEL or fewer visible words. Once settled, it is 1 with AE_LEVEL words stored and 0 with AE_LEVEL+1.
- R10: While `out_ready` is 1 and no read is made, `out_ready` stays 1 and `rd_data` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for write, read and stage-to-stage transfer |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Write request at the head stage |
| wr_data | input | WIDTH | Word to write |
| in_ready | output | 1 | Head stage can accept a word |
| almost_full | output | 1 | Head stage free space at or below AF_LEVEL |
| rd_en | input | 1 | Read request at the tail stage |
| rd_data | output | WIDTH | Oldest word, valid while out_ready is 1 |
| out_ready | output | 1 | Tail stage holds a visible word |
| almost_empty | output | 1 | Tail stage visible words at or below AE_LEVEL |

## Verification
The hardest situation to reach is the worst-case drain path. Every stage must be completely full and every hop blocked, so that one read at the tail has to ripple a freed slot back through each boundary before the head shows any space. The bench gets there by holding the write request high, with distinct dummy data whenever the head refuses, until exactly the capacity has been accepted. It then idles long enough for all pending transfers to land. Only after that does it issue one read and count the edges until `in_ready` rises.

// File: rtl/cfc_pkg.sv
package cfc_pkg;

  // Edges from an accepted write until the word counts as visible in a stage
  localparam int WR_TO_VIS   = 3;
  // Edges from an accepted read until the slot counts as free in a stage
  localparam int FREE_TO_VIS = 2;

  // Edges from a write at the head until the tail shows out-ready
  function automatic int fill_latency(input int n_stages);
    return (n_stages - 1) * (WR_TO_VIS + 1) + WR_TO_VIS;
  endfunction

  // Edges from a read at the tail until the head shows in-ready
  function automatic int drain_latency(input int n_stages);
    return (n_stages - 1) * (FREE_TO_VIS + 1) + FREE_TO_VIS;
  endfunction

  function automatic int cnt_width(input int depth);
    return $clog2(depth + 1);
  endfunction

  function automatic int ptr_width(input int depth);
    return (depth > 1) ? $clog2(depth) : 1;
  endfunction

endpackage

// File: rtl/cfc_pulse_delay.sv
module cfc_pulse_delay #(
  parameter int DLY = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           pulse_i,
  output logic           pulse_o,
  output logic [DLY-1:0] taps_o
);

  // Shift chain: taps_o[0] is the pulse one edge late, taps_o[DLY-1] is DLY edges late
  for (genvar g = 0; g < DLY; g++) begin : g_tap
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) taps_o[g] <= 1'b0;
        else     taps_o[g] <= pulse_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) taps_o[g] <= 1'b0;
        else     taps_o[g] <= taps_o[g-1];
      end
    end
  end

  assign pulse_o = taps_o[DLY-1];

endmodule

// File: rtl/cfc_stage.sv
module cfc_stage #(
  parameter int WIDTH    = 16,
  parameter int DEPTH    = 8,
  parameter int AF_LEVEL = 2,
  parameter int AE_LEVEL = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push_req,
  input  logic [WIDTH-1:0] push_data,
  output logic             in_ready,
  input  logic             pop_req,
  output logic [WIDTH-1:0] out_data,
  output logic             out_ready,
  output logic             almost_full,
  output logic             almost_empty
);
  import cfc_pkg::*;

  localparam int PTR_W = ptr_width(DEPTH);
  localparam int CNT_W = cnt_width(DEPTH);
  localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic [CNT_W-1:0] avail, space;
  logic [CNT_W-1:0] avail_nxt, space_nxt;

  // Named internal events
  logic push_ok, pop_ok;
  logic push_seen, pop_seen;
  logic [WR_TO_VIS-1:0]   push_taps;
  logic [FREE_TO_VIS-1:0] pop_taps;

  assign push_ok = push_req && in_ready;
  assign pop_ok  = pop_req  && out_ready;

  cfc_pulse_delay #(.DLY(WR_TO_VIS)) u_push_dly (
    .clk     (clk),
    .rst     (rst),
    .pulse_i (push_ok),
    .pulse_o (push_seen),
    .taps_o  (push_taps)
  );

  cfc_pulse_delay #(.DLY(FREE_TO_VIS)) u_pop_dly (
    .clk     (clk),
    .rst     (rst),
    .pulse_i (pop_ok),
    .pulse_o (pop_seen),
    .taps_o  (pop_taps)
  );

  always_comb begin
    avail_nxt = avail;
    if (push_seen) avail_nxt = avail_nxt + CNT_W'(1);
    if (pop_ok)    avail_nxt = avail_nxt - CNT_W'(1);
    space_nxt = space;
    if (pop_seen)  space_nxt = space_nxt + CNT_W'(1);
    if (push_ok)   space_nxt = space_nxt - CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr  <= '0;
      rptr  <= '0;
      avail <= '0;
      space <= CNT_W'(DEPTH);
    end else begin
      if (push_ok) wptr <= (wptr == LAST_SLOT) ? '0 : wptr + PTR_W'(1);
      if (pop_ok)  rptr <= (rptr == LAST_SLOT) ? '0 : rptr + PTR_W'(1);
      avail <= avail_nxt;
      space <= space_nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= push_data;
  end

  assign out_data     = mem[rptr];
  assign out_ready    = (avail != '0);
  assign in_ready     = (space != '0);
  assign almost_full  = (space <= CNT_W'(AF_LEVEL));
  assign almost_empty = (avail <= CNT_W'(AE_LEVEL));

  // R3: visible words, free slots and words or slots still in flight always total the depth
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (rst)
    (int'(avail) + int'(space) + $countones(push_taps) + $countones(pop_taps)) == DEPTH);

  // R6: a refused write leaves the write pointer where it was
  assert_ignore_write_R6: assert property (@(posedge clk) disable iff (rst)
    (push_req && !in_ready) |=> $stable(wptr));

  // R7: a refused read leaves the read pointer where it was
  assert_ignore_read_R7: assert property (@(posedge clk) disable iff (rst)
    (pop_req && !out_ready) |=> $stable(rptr));

  // R4: a word becomes visible only when its delayed write pulse arrives
  assert_no_early_data_R4: assert property (@(posedge clk) disable iff (rst)
    (!out_ready && !push_seen) |=> !out_ready);

  // R5: a slot becomes free only when its delayed read pulse arrives
  assert_no_early_space_R5: assert property (@(posedge clk) disable iff (rst)
    (!in_ready && !pop_seen) |=> !in_ready);

endmodule

// File: rtl/cfc_chain_fifo.sv
module cfc_chain_fifo #(
  parameter int WIDTH       = 16,
  parameter int N_STAGES    = 3,
  parameter int STAGE_DEPTH = 8,
  parameter int AF_LEVEL    = 2,
  parameter int AE_LEVEL    = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [WIDTH-1:0] wr_data,
  output logic             in_ready,
  output logic             almost_full,
  input  logic             rd_en,
  output logic [WIDTH-1:0] rd_data,
  output logic             out_ready,
  output logic             almost_empty
);
  import cfc_pkg::*;

  localparam int LAST = N_STAGES - 1;
  localparam int MAX_IN_FLIGHT = WR_TO_VIS + FREE_TO_VIS;

  logic [N_STAGES-1:0] push_s, pop_s, ir_s, or_s, af_s, ae_s;
  logic [WIDTH-1:0]    din_s  [N_STAGES];
  logic [WIDTH-1:0]    dout_s [N_STAGES];
  // hop_s[i]: a word moves from stage i-1 into stage i on this edge
  logic [N_STAGES-1:0] hop_s;

  for (genvar i = 0; i < N_STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      assign hop_s[i]  = 1'b0;
      assign push_s[i] = wr_en;
      assign din_s[i]  = wr_data;
    end else begin : g_inner
      assign hop_s[i]  = or_s[i-1] && ir_s[i];
      assign push_s[i] = hop_s[i];
      assign din_s[i]  = dout_s[i-1];
    end

    if (i == LAST) begin : g_tail
      assign pop_s[i] = rd_en;
    end else begin : g_pass
      assign pop_s[i] = hop_s[i+1];
    end

    cfc_stage #(
      .WIDTH    (WIDTH),
      .DEPTH    (STAGE_DEPTH),
      .AF_LEVEL (AF_LEVEL),
      .AE_LEVEL (AE_LEVEL)
    ) u_stage (
      .clk          (clk),
      .rst          (rst),
      .push_req     (push_s[i]),
      .push_data    (din_s[i]),
      .in_ready     (ir_s[i]),
      .pop_req      (pop_s[i]),
      .out_data     (dout_s[i]),
      .out_ready    (or_s[i]),
      .almost_full  (af_s[i]),
      .almost_empty (ae_s[i])
    );

    // R9: a stage reporting almost-empty can never be out of space
    if (STAGE_DEPTH > AE_LEVEL + MAX_IN_FLIGHT) begin : g_ae_chk
      assert_ae_not_full_R9: assert property (@(posedge clk) disable iff (rst)
        ae_s[i] |-> ir_s[i]);
    end
    // R8: a stage reporting almost-full always has a word to offer
    if (STAGE_DEPTH > AF_LEVEL + MAX_IN_FLIGHT) begin : g_af_chk
      assert_af_has_data_R8: assert property (@(posedge clk) disable iff (rst)
        af_s[i] |-> or_s[i]);
    end
  end

  assign in_ready     = ir_s[0];
  assign almost_full  = af_s[0];
  assign out_ready    = or_s[LAST];
  assign almost_empty = ae_s[LAST];
  assign rd_data      = dout_s[LAST];

  // R10: the presented word stays put until it is read
  assert_hold_word_R10: assert property (@(posedge clk) disable iff (rst)
    (out_ready && !rd_en) |=> (out_ready && $stable(rd_data)));

endmodule

// File: tb/tb_cfc_chain_fifo.sv
module tb_cfc_chain_fifo;
  localparam int W   = 16;
  localparam int N   = 3;
  localparam int D   = 8;
  localparam int AF  = 2;
  localparam int AE  = 2;
  localparam int CAP = N * D;
  localparam int FILL_EDGES  = 4 * (N - 1) + 3;
  localparam int DRAIN_EDGES = 3 * (N - 1) + 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [W-1:0] wr_data = '0;
  logic rd_en = 1'b0;
  logic in_ready, almost_full, out_ready, almost_empty;
  logic [W-1:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] model [$];
  logic [W-1:0] next_val = 16'h0100;

  always #5 clk = ~clk;

  cfc_chain_fifo #(
    .WIDTH(W), .N_STAGES(N), .STAGE_DEPTH(D), .AF_LEVEL(AF), .AE_LEVEL(AE)
  ) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
    .in_ready(in_ready), .almost_full(almost_full),
    .rd_en(rd_en), .rd_data(rd_data),
    .out_ready(out_ready), .almost_empty(almost_empty)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_word(input logic [W-1:0] val);
    int t = 0;
    while (!in_ready && t < 500) begin @(negedge clk); t++; end
    wr_en = 1'b1; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
    model.push_back(val);
  endtask

  task automatic pop_word(input string req);
    int t = 0;
    while (!out_ready && t < 500) begin @(negedge clk); t++; end
    chk(req, "read order", rd_data, model[0]);
    void'(model.pop_front());
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic drain_all(input string req);
    while (model.size() > 0) pop_word(req);
  endtask

  task automatic t_reset();
    rst = 1'b1;
    idle(4);
    chk("R1", "in_ready in reset", in_ready, 1);
    chk("R1", "out_ready in reset", out_ready, 0);
    rst = 1'b0;
    idle(3);
    chk("R1", "in_ready", in_ready, 1);
    chk("R1", "out_ready", out_ready, 0);
    chk("R1", "almost_full", almost_full, 0);
    chk("R1", "almost_empty", almost_empty, 1);
  endtask

  task automatic t_fill_latency();
    int first = -1;
    wr_en = 1'b1; wr_data = 16'h1234;
    @(negedge clk);
    wr_en = 1'b0;
    model.push_back(16'h1234);
    for (int k = 0; k < 40; k++) begin
      if (out_ready && first < 0) first = k;
      @(negedge clk);
    end
    chk("R4", "fill latency edges", first, FILL_EDGES);
    idle(5);
    chk("R10", "out_ready held", out_ready, 1);
    chk("R10", "rd_data held", rd_data, 16'h1234);
    pop_word("R2");
  endtask

  task automatic t_almost_empty();
    for (int i = 0; i < AE; i++) push_word(16'h2000 + 16'(i));
    idle(40);
    chk("R9", "almost_empty at AE words", almost_empty, 1);
    push_word(16'h2100);
    idle(40);
    chk("R9", "almost_empty at AE+1 words", almost_empty, 0);
    drain_all("R9");
    idle(20);
    chk("R9", "almost_empty after drain", almost_empty, 1);
  endtask

  task automatic t_read_empty();
    idle(10);
    for (int i = 0; i < 10; i++) begin rd_en = 1'b1; @(negedge clk); end
    rd_en = 1'b0;
    chk("R7", "out_ready after empty reads", out_ready, 0);
    push_word(16'hBEEF);
    idle(40);
    chk("R7", "out_ready after one write", out_ready, 1);
    chk("R7", "word after empty reads", rd_data, 16'hBEEF);
    pop_word("R7");
    idle(20);
    chk("R7", "empty again", out_ready, 0);
  endtask

  task automatic t_capacity_and_drain();
    int accepted = 0;
    int first = -1;
    for (int c = 0; c < 200; c++) begin
      wr_en = 1'b1;
      if (in_ready) begin
        wr_data = next_val;
        model.push_back(next_val);
        next_val++;
        accepted++;
      end else begin
        wr_data = 16'hDEAD;
      end
      @(negedge clk);
    end
    wr_en = 1'b0;
    idle(60);
    chk("R3", "words accepted", accepted, CAP);
    chk("R3", "in_ready when full", in_ready, 0);
    chk("R8", "almost_full when full", almost_full, 1);
    // R6: extra writes while full must leave no trace
    for (int i = 0; i < 6; i++) begin wr_en = 1'b1; wr_data = 16'hDEAD; @(negedge clk); end
    wr_en = 1'b0;
    idle(10);
    chk("R6", "in_ready still low", in_ready, 0);
    // R5: one read from the full chain
    chk("R2", "head word when full", rd_data, model[0]);
    void'(model.pop_front());
    rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    for (int k = 0; k < 40; k++) begin
      if (in_ready && first < 0) first = k;
      @(negedge clk);
    end
    chk("R5", "drain latency edges", first, DRAIN_EDGES);
    drain_all("R6");
  endtask

  task automatic t_almost_full();
    idle(40);
    for (int i = 0; i < (N - 1) * D + D - AF - 1; i++) push_word(16'h3000 + 16'(i));
    idle(60);
    chk("R8", "almost_full one below level", almost_full, 0);
    push_word(16'h3FFF);
    idle(60);
    chk("R8", "almost_full at level", almost_full, 1);
    drain_all("R2");
  endtask

  task automatic t_stream();
    fork
      begin
        for (int i = 0; i < 40; i++) begin
          push_word(16'h5000 + 16'(i));
          if (i % 3 == 0) idle(2);
        end
      end
      begin
        for (int i = 0; i < 40; i++) begin
          pop_word("R2");
          if (i % 5 == 0) idle(3);
        end
      end
    join
    chk("R2", "stream leftover", model.size(), 0);
  endtask

  initial begin
    @(negedge clk);
    t_reset();
    t_fill_latency();
    t_almost_empty();
    t_read_empty();
    t_capacity_and_drain();
    t_almost_full();
    t_stream();
    idle(5);
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule